// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the combinational arithmetic and logic stage of a small accumulator processor. Each cycle the surrounding datapath presents an operation code, two operands and the current carry flag. The block returns a result and next values for the carry, zero, overflow and negative flags. It also returns a mask that tells the status register which of those four flags the operation is allowed to write. The block holds no state, and decimal arithmetic is not handled here.

Operand `a` is the accumulator-side value. Shifts, rotates, increment and decrement act on `a` alone. Compare and bit test leave `a` unchanged on the result bus, so the register file can write back unconditionally. Subtraction reuses the adder on the inverted `b`, so the incoming carry acts as "no borrow".

Top module: `alu_flagcore`

## Requirements
- R1: Operation code 0 (add) gives result = low 8 bits of a + b + carry_in, and carry_out = bit 8 of that 9-bit sum.
- R2: On add, overflow_out is 1 exactly when a and b have equal bit 7 and the result's bit 7 differs from a's.
- R3: Operation code 1 (subtract) computes a + ~b + carry_in. carry_out = 1 means no borrow. Overflow follows the rule of R2 with ~b in place of b.
- R4: Operation code 2 (compare) drives result = a and carry_out = (b <= a) unsigned. Zero and negative come from the 8-bit a - b.
- R5: Codes 3, 4 and 5 (AND, OR, XOR) give a op b and set mask = 4'b0101 (zero and negative only).
- R6: Code 6 (shift left) moves a[7] into carry with a 0 entering bit 0. Code 7 (logical shift right) moves a[0] into carry with a 0 entering bit 7, so negative is 0.
- R7: Code 8 (rotate left) puts carry_in into bit 0 and a[7] into carry. Code 9 (rotate right) puts carry_in into bit 7 and a[0] into carry.
- R8: Codes 10 and 11 (increment, decrement) give a+1 and a-1 modulo 256, with negative = result bit 7 and zero = (result == 0). Their mask is 4'b0101.
- R9: Code 12 (bit test) drives result = a, negative = b[7], overflow = b[6] and zero = ((a & b) == 0), with mask 4'b0111.
- R10: Mask bits are [3]=carry, [2]=zero, [1]=overflow, [0]=negative. Add and subtract give 4'b1111. Compare and the four shift/rotate codes give 4'b1101.
- R11: Codes 13 to 15 pass a to the result with mask 4'b0000.
- R12: A flag whose mask bit is clear is driven as follows: carry_out equals carry_in, and zero, overflow and negative are 0.
- R13: Zero is 1 exactly when the 8-bit value that the operation's flags are taken from equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (see requirements) |
| a | input | 8 | Accumulator-side operand |
| b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |
| overflow_out | output | 1 | Next overflow flag |
| negative_out | output | 1 | Next negative flag |
| flag_mask | output | 4 | Flags written by this operation {C,Z,V,N} |

## Verification
The bench works on signed overflow at the 0x7F/0x80 boundary in both directions. A design that tested the result sign alone, or that ignored the inverted operand on subtract, would flag 0x80-0x01 wrongly. Compare at equal operands must give carry set and zero set; an off-by-one borrow would clear carry. Rotates are driven with carry_in set, so a design that shifted in 0 loses the top or bottom bit. Bit test is driven with an operand whose bits 7 and 6 differ from the AND result, so a design taking the flags from a & b gives the wrong negative and overflow. Unused codes and logic operations check that carry passes through, since a block that cleared it would corrupt the status register.

// File: rtl/alu_flagcore.sv
module alu_flagcore #(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_out,
  output logic             overflow_out,
  output logic             negative_out,
  output logic [3:0]       flag_mask
);
  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_CMP = 4'd2;
  localparam logic [3:0] OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_SHL = 4'd6;
  localparam logic [3:0] OP_SHR = 4'd7;
  localparam logic [3:0] OP_RLC = 4'd8;
  localparam logic [3:0] OP_RRC = 4'd9;
  localparam logic [3:0] OP_INC = 4'd10;
  localparam logic [3:0] OP_DEC = 4'd11;
  localparam logic [3:0] OP_TST = 4'd12;

  localparam logic [3:0] M_ALL   = 4'b1111;
  localparam logic [3:0] M_CZN   = 4'b1101;
  localparam logic [3:0] M_ZN    = 4'b0101;
  localparam logic [3:0] M_ZVN   = 4'b0111;
  localparam logic [3:0] M_NONE  = 4'b0000;

  logic             invert_b;
  logic [WIDTH-1:0] b_eff;
  logic             cin_eff;
  logic [WIDTH:0]   sum;
  logic             sum_ovf;

  assign invert_b = (op == OP_SUB) || (op == OP_CMP);
  assign b_eff    = invert_b ? ~b : b;
  assign cin_eff  = (op == OP_CMP) ? 1'b1 : carry_in;
  assign sum      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
  assign sum_ovf  = ~(a[MSB] ^ b_eff[MSB]) & (a[MSB] ^ sum[MSB]);

  logic [WIDTH-1:0] res_v;
  logic [WIDTH-1:0] flag_src;
  logic             c_v;
  logic             v_v;
  logic [3:0]       m_v;
  logic             n_force;

  always_comb begin
    res_v    = a;
    flag_src = a;
    c_v      = carry_in;
    v_v      = 1'b0;
    m_v      = M_NONE;
    n_force  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_v    = sum[MSB:0];
        flag_src = sum[MSB:0];
        c_v      = sum[WIDTH];
        v_v      = sum_ovf;
        m_v      = M_ALL;
      end
      OP_CMP: begin
        flag_src = sum[MSB:0];
        c_v      = sum[WIDTH];
        m_v      = M_CZN;
      end
      OP_AND: begin
        res_v    = a & b;
        flag_src = res_v;
        m_v      = M_ZN;
      end
      OP_OR: begin
        res_v    = a | b;
        flag_src = res_v;
        m_v      = M_ZN;
      end
      OP_XOR: begin
        res_v    = a ^ b;
        flag_src = res_v;
        m_v      = M_ZN;
      end
      OP_SHL: begin
        res_v    = {a[MSB-1:0], 1'b0};
        flag_src = res_v;
        c_v      = a[MSB];
        m_v      = M_CZN;
      end
      OP_SHR: begin
        res_v    = {1'b0, a[MSB:1]};
        flag_src = res_v;
        c_v      = a[0];
        m_v      = M_CZN;
      end
      OP_RLC: begin
        res_v    = {a[MSB-1:0], carry_in};
        flag_src = res_v;
        c_v      = a[MSB];
        m_v      = M_CZN;
      end
      OP_RRC: begin
        res_v    = {carry_in, a[MSB:1]};
        flag_src = res_v;
        c_v      = a[0];
        m_v      = M_CZN;
      end
      OP_INC: begin
        res_v    = a + 1'b1;
        flag_src = res_v;
        m_v      = M_ZN;
      end
      OP_DEC: begin
        res_v    = a - 1'b1;
        flag_src = res_v;
        m_v      = M_ZN;
      end
      OP_TST: begin
        flag_src = a & b;
        n_force  = 1'b1;
        v_v      = b[MSB-1];
        m_v      = M_ZVN;
      end
      default: begin
        res_v = a;
        m_v   = M_NONE;
      end
    endcase
  end

  logic n_raw;
  assign n_raw = n_force ? b[MSB] : flag_src[MSB];

  assign result       = res_v;
  assign flag_mask    = m_v;
  assign carry_out    = m_v[3] ? c_v : carry_in;
  assign zero_out     = m_v[2] & (flag_src == '0);
  assign overflow_out = m_v[1] & v_v;
  assign negative_out = m_v[0] & n_raw;
endmodule

// File: rtl/alu_flagcore_chk.sv
module alu_flagcore_chk #(
  parameter int WIDTH = 8
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero_out,
  input logic             overflow_out,
  input logic             negative_out,
  input logic [3:0]       flag_mask
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] add9;
  assign add9 = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (op == 4'd0) begin
      assert_add_sum_R1: assert ({carry_out, result} == add9);
    end
    if (op == 4'd2) begin
      assert_cmp_keeps_a_R4: assert (result == a && carry_out == (b <= a));
    end
    if (op == 4'd3 || op == 4'd4 || op == 4'd5) begin
      assert_logic_mask_R5: assert (flag_mask == 4'b0101);
    end
    if (op == 4'd8) begin
      assert_rol_carry_R7: assert (result[0] == carry_in && carry_out == a[MSB]);
    end
    if (op == 4'd12) begin
      assert_bit_copy_R9: assert (negative_out == b[MSB] && overflow_out == b[MSB-1] && result == a);
    end
    if (op >= 4'd13) begin
      assert_unused_pass_R11: assert (result == a && flag_mask == 4'b0000);
    end
    if (!flag_mask[3]) begin
      assert_carry_hold_R12: assert (carry_out == carry_in);
    end
    if (!flag_mask[1]) begin
      assert_no_overflow_R12: assert (!overflow_out);
    end
  end
endmodule

bind alu_flagcore alu_flagcore_chk #(.WIDTH(WIDTH)) u_chk (
  .op(op), .a(a), .b(b), .carry_in(carry_in), .result(result),
  .carry_out(carry_out), .zero_out(zero_out), .overflow_out(overflow_out),
  .negative_out(negative_out), .flag_mask(flag_mask)
);

// File: tb/tb_alu_flagcore.sv
module tb_alu_flagcore;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a, b;
  logic       carry_in;
  logic [7:0] result;
  logic       carry_out, zero_out, overflow_out, negative_out;
  logic [3:0] flag_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  alu_flagcore dut (
    .op(op), .a(a), .b(b), .carry_in(carry_in), .result(result),
    .carry_out(carry_out), .zero_out(zero_out), .overflow_out(overflow_out),
    .negative_out(negative_out), .flag_mask(flag_mask)
  );

  // {op, a, b, cin, result, flags{C,Z,V,N}, mask}
  localparam int NV = 21;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 4'b0011, 4'b1111}, // R2 positive overflow
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b1100, 4'b1111}, // R1 R13 carry out
    {4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 4'b1110, 4'b1111}, // R2 negative overflow
    {4'd0,  8'h10, 8'h20, 1'b1, 8'h31, 4'b0000, 4'b1111}, // R1 carry in
    {4'd1,  8'h50, 8'h10, 1'b1, 8'h40, 4'b1000, 4'b1111}, // R3
    {4'd1,  8'h00, 8'h01, 1'b1, 8'hFF, 4'b0001, 4'b1111}, // R3 borrow
    {4'd1,  8'h80, 8'h01, 1'b1, 8'h7F, 4'b1010, 4'b1111}, // R3 overflow
    {4'd1,  8'h05, 8'h03, 1'b0, 8'h01, 4'b1000, 4'b1111}, // R3 borrow in
    {4'd2,  8'h40, 8'h40, 1'b0, 8'h40, 4'b1100, 4'b1101}, // R4 equal
    {4'd2,  8'h10, 8'h20, 1'b1, 8'h10, 4'b0001, 4'b1101}, // R4 less
    {4'd3,  8'hF0, 8'h0F, 1'b1, 8'h00, 4'b1100, 4'b0101}, // R5 R12
    {4'd4,  8'h80, 8'h01, 1'b0, 8'h81, 4'b0001, 4'b0101}, // R5
    {4'd5,  8'hFF, 8'hFF, 1'b0, 8'h00, 4'b0100, 4'b0101}, // R5
    {4'd6,  8'h81, 8'h00, 1'b0, 8'h02, 4'b1000, 4'b1101}, // R6
    {4'd7,  8'h01, 8'h00, 1'b0, 8'h00, 4'b1100, 4'b1101}, // R6
    {4'd8,  8'h80, 8'h00, 1'b1, 8'h01, 4'b1000, 4'b1101}, // R7
    {4'd9,  8'h01, 8'h00, 1'b1, 8'h80, 4'b1001, 4'b1101}, // R7
    {4'd10, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b0100, 4'b0101}, // R8
    {4'd11, 8'h00, 8'h00, 1'b1, 8'hFF, 4'b1001, 4'b0101}, // R8 R12
    {4'd12, 8'h0F, 8'hC0, 1'b0, 8'h0F, 4'b0111, 4'b0111}, // R9
    {4'd13, 8'h5A, 8'hA5, 1'b1, 8'h5A, 4'b1000, 4'b0000}  // R11
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1 R2 R10";
      4'd1: return "R3 R10";
      4'd2: return "R4 R10";
      4'd3, 4'd4, 4'd5: return "R5 R12";
      4'd6, 4'd7: return "R6 R10";
      4'd8, 4'd9: return "R7 R10";
      4'd10, 4'd11: return "R8 R12";
      4'd12: return "R9";
      default: return "R11 R12";
    endcase
  endfunction

  // Reference: returns {result, C, Z, V, N, mask}
  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic ci);
    logic [7:0] r, src;
    logic c, v, n;
    logic [3:0] m;
    int s;
    r = x; src = x; c = ci; v = 0; m = 4'b0000;
    case (o)
      4'd0: begin s = int'(x) + int'(y) + int'(ci); r = s[7:0]; src = r; c = s[8];
              v = (x[7] == y[7]) && (r[7] != x[7]); m = 4'b1111; end
      4'd1: begin s = int'(x) + int'(8'(~y)) + int'(ci); r = s[7:0]; src = r; c = s[8];
              v = (x[7] != y[7]) && (r[7] != x[7]); m = 4'b1111; end
      4'd2: begin src = x - y; c = (y <= x); m = 4'b1101; end
      4'd3: begin r = x & y; src = r; m = 4'b0101; end
      4'd4: begin r = x | y; src = r; m = 4'b0101; end
      4'd5: begin r = x ^ y; src = r; m = 4'b0101; end
      4'd6: begin r = x << 1; src = r; c = x[7]; m = 4'b1101; end
      4'd7: begin r = x >> 1; src = r; c = x[0]; m = 4'b1101; end
      4'd8: begin r = {x[6:0], ci}; src = r; c = x[7]; m = 4'b1101; end
      4'd9: begin r = {ci, x[7:1]}; src = r; c = x[0]; m = 4'b1101; end
      4'd10: begin r = x + 8'd1; src = r; m = 4'b0101; end
      4'd11: begin r = x - 8'd1; src = r; m = 4'b0101; end
      4'd12: begin src = x & y; v = y[6]; m = 4'b0111; end
      default: ;
    endcase
    n = (o == 4'd12) ? y[7] : src[7];
    if (!m[3]) c = ci;
    return {r, c, m[2] & (src == 8'h00), m[1] & v, m[0] & n, m};
  endfunction

  task automatic check(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic ci, input logic [7:0] er, input logic [3:0] ef,
                       input logic [3:0] em, input string tag);
    @(negedge clk);
    op = o; a = x; b = y; carry_in = ci;
    @(posedge clk); #1;
    checks++;
    if (result !== er || {carry_out, zero_out, overflow_out, negative_out} !== ef ||
        flag_mask !== em) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b: got res=%h f=%b m=%b exp res=%h f=%b m=%b",
               tag, o, x, y, ci, result,
               {carry_out, zero_out, overflow_out, negative_out}, flag_mask, er, ef, em);
    end
  endtask

  task automatic check_model(input logic [3:0] o, input logic [7:0] x,
                             input logic [7:0] y, input logic ci);
    logic [15:0] e;
    e = model(o, x, y, ci);
    check(o, x, y, ci, e[15:8], e[7:4], e[3:0], req_of(o));
  endtask

  initial begin
    op = 4'd0; a = 8'h00; b = 8'h00; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // Quiescent output with all-zero inputs: add 0+0 gives zero set (R13, R1)
    checks++;
    if (result !== 8'h00 || {carry_out, zero_out, overflow_out, negative_out} !== 4'b0100 ||
        flag_mask !== 4'b1111) begin
      failures++;
      $display("FAIL R13 idle: got res=%h f=%b exp res=00 f=0100",
               result, {carry_out, zero_out, overflow_out, negative_out});
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      check(VEC[i][36:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16],
            VEC[i][15:8], VEC[i][7:4], VEC[i][3:0], req_of(VEC[i][36:33]));
    end

    // Edge operands across every code: 0x00, 0x7F, 0x80, 0xFF
    for (int o = 0; o < 16; o++)
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int ic = 0; ic < 2; ic++) begin
            logic [7:0] ea, eb;
            ea = (ia == 0) ? 8'h00 : (ia == 1) ? 8'h7F : (ia == 2) ? 8'h80 : 8'hFF;
            eb = (ib == 0) ? 8'h00 : (ib == 1) ? 8'h7F : (ib == 2) ? 8'h80 : 8'hFF;
            check_model(4'(o), ea, eb, 1'(ic));
          end

    // Random operands
    for (int k = 0; k < 3000; k++) begin
      check_model(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom));
    end

    // Directed: compare with b = a+1 clears carry, b = a-1 sets it (R4)
    check(4'd2, 8'h7F, 8'h80, 1'b1, 8'h7F, 4'b0001, 4'b1101, "R4 below");
    check(4'd2, 8'h80, 8'h7F, 1'b0, 8'h80, 4'b1000, 4'b1101, "R4 above");
    // Logical shift right of 0xFF clears negative (R6)
    check(4'd7, 8'hFF, 8'h00, 1'b1, 8'h7F, 4'b1000, 4'b1101, "R6 lsr neg");
    // Rotate right with carry clear (R7)
    check(4'd9, 8'h80, 8'h00, 1'b0, 8'h40, 4'b0000, 4'b1101, "R7 ror");
    // Increment across sign boundary (R8)
    check(4'd10, 8'h7F, 8'h00, 1'b0, 8'h80, 4'b0001, 4'b0101, "R8 inc");
    // Bit test where a & b nonzero and b[7:6] = 01 (R9)
    check(4'd12, 8'hFF, 8'h41, 1'b1, 8'hFF, 4'b1010, 4'b0111, "R9 bit");
    // Unused code 15 keeps carry clear and passes a (R11, R12)
    check(4'd15, 8'h00, 8'hFF, 1'b0, 8'h00, 4'b0000, 4'b0000, "R11 R12 op15");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule